// File: doc/BRIEF.md
# Receive Parity Substitution Pipeline

This block sits between a character receiver and a recirculating display memory. Each received character arrives as seven data bits plus one parity bit, marked by a one-cycle valid strobe. The block follows the framing of a message: a start-of-text character, then an address character, then the body. It passes the address and body characters through a short chain of character registers. The last register of the chain writes into the memory whenever the memory offers a write slot.

Body characters are checked for parity. When a body character fails the check, a fixed code that displays as a blank space takes its place in the first register. The blank code then moves down the chain and into memory in the same position as the bad character. A saturating counter records how many substitutions have been made.

In polling mode, an address character with its top data bit set ends reception. The block clears its frame flag, drops its receive-enable level and examines only the next character. If that character is end-of-text, a transmit request is armed. The armed request fires a one-cycle transmit-start pulse when the memory side reports that it has found an end-of-text code.

Top module: `rx_parity_subst`

## Requirements
- R1: After reset, no memory write is issued, `frame_open` is 0, `rx_enable` is 1, `etx_armed` is 0, `xmit_start` is 0 and `perr_count` is 0.
- R2: While no frame is open, every character is dropped unless its low seven bits equal 7'h02 (start-of-text). That character opens a frame (`frame_open` = 1) and is itself never written to memory.
- R3: The first character after start-of-text is the address. Its parity is not checked, and its low seven bits are written to memory unchanged, except in the case covered by R9.
- R4: A body character with correct parity is written unchanged. The parity is odd by default: the XOR of all eight bits, with the parity bit at bit 7, must be 1. Characters reach memory in the order they were received.
- R5: A body character with wrong parity is replaced by 7'h1A (the blank-display code). The replacement is written in the bad character's place in the sequence.
- R6: `perr_count` rises by one for each substitution and holds once it reaches its all-ones value.
- R7: A write happens only in a cycle with `mem_slot` high while the chain holds a character, and no character is lost or reordered. With `mem_slot` held high, a character accepted at clock edge t appears on `mem_wr` in the cycle after edge t+2.
- R8: A body character equal to 7'h03 (end-of-text) with correct parity is written and closes the frame. An end-of-text with wrong parity is substituted and the frame stays open.
- R9: With `poll_mode` = 1, an address whose bit 6 is 1 is not written, clears `frame_open` and drops `rx_enable`. The next character is also not written. If that next character equals 7'h03 it sets `etx_armed`. Either way, reception then returns to waiting for start-of-text with `rx_enable` = 1.
- R10: With `poll_mode` = 0, bit 6 of the address has no special meaning and the address is handled as in R3.
- R11: `xmit_start` pulses for one cycle in the cycle after `mem_etx_hit` is seen while armed, and that clears the arm. If a new arm and `mem_etx_hit` coincide, the pulse follows only from the earlier arm, and the new arm is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_mode | input | 1 | 1 selects polling conversational handling of the address |
| rx_valid | input | 1 | One-cycle strobe: `rx_char` holds a new character |
| rx_char | input | 8 | Bits 6:0 data, bit 7 parity |
| mem_slot | input | 1 | Memory can take one character this cycle |
| mem_etx_hit | input | 1 | Memory scan has found an end-of-text code |
| mem_wr | output | 1 | Write strobe to memory |
| mem_data | output | 7 | Character written to memory |
| frame_open | output | 1 | Start-of-text seen, frame in progress |
| rx_enable | output | 1 | Receive-enable level, low while the polling address blocks reception |
| etx_armed | output | 1 | Transmit request armed, waiting for end-of-text in memory |
| xmit_start | output | 1 | One-cycle transmit-start pulse |
| perr_count | output | CNT_W | Saturating count of parity substitutions |

## Verification
Two events can land in the same cycle. One is the arrival of the end-of-text that arms a transmit request, behind a polling address. The other is the memory reporting an end-of-text hit. The bench drives both in one cycle, once with an older arm pending and once with none. It expects a pulse only in the first case and the new arm to survive in both. A second overlap occurs when the chain loads its first stage while that stage is emptying and the last stage writes to memory. Random write-slot gaps provoke it, and an in-order comparison of every write against a model queue judges it.

// File: rtl/rxps_pkg.sv
package rxps_pkg;
  localparam int CHAR_W = 7;

  localparam logic [CHAR_W-1:0] CODE_SOT   = 7'h02;
  localparam logic [CHAR_W-1:0] CODE_EOT   = 7'h03;
  localparam logic [CHAR_W-1:0] CODE_BLANK = 7'h1A;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_ADDR = 2'd1,
    FS_BODY = 2'd2,
    FS_MUTE = 2'd3
  } frame_state_e;

  // XOR of all eight bits equals 1 under odd parity, 0 under even
  function automatic logic parity_good(input logic [CHAR_W:0] c, input logic odd);
    return (^c) == odd;
  endfunction

  function automatic logic is_code(input logic [CHAR_W-1:0] c, input logic [CHAR_W-1:0] code);
    return c == code;
  endfunction
endpackage

// File: rtl/rxps_parity_check.sv
module rxps_parity_check
  import rxps_pkg::*;
#(
  parameter bit ODD_PARITY = 1'b1
) (
  input  logic [CHAR_W:0] char_in,
  output logic            par_good
);
  assign par_good = parity_good(char_in, ODD_PARITY);
endmodule

// File: rtl/rxps_frame_ctrl.sv
module rxps_frame_ctrl
  import rxps_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_mode,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              par_good,
  input  logic              mem_etx_hit,
  output logic              push,
  output logic [CHAR_W-1:0] push_data,
  output logic              subst_evt,
  output logic              frame_open,
  output logic              rx_enable,
  output logic              etx_armed,
  output logic              xmit_start,
  output logic [CNT_W-1:0]  perr_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  frame_state_e state_q, state_d;
  logic         arm_evt;
  logic         armed_q, xmit_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d   = state_q;
    push      = 1'b0;
    push_data = rx_data;
    subst_evt = 1'b0;
    arm_evt   = 1'b0;
    if (rx_valid) begin
      unique case (state_q)
        FS_IDLE: if (is_code(rx_data, CODE_SOT)) state_d = FS_ADDR;
        FS_ADDR: begin
          if (poll_mode && rx_data[CHAR_W-1]) begin
            state_d = FS_MUTE;
          end else begin
            push    = 1'b1;
            state_d = FS_BODY;
          end
        end
        FS_BODY: begin
          push = 1'b1;
          if (!par_good) begin
            push_data = CODE_BLANK;
            subst_evt = 1'b1;
          end else if (is_code(rx_data, CODE_EOT)) begin
            state_d = FS_IDLE;
          end
        end
        FS_MUTE: begin
          arm_evt = is_code(rx_data, CODE_EOT);
          state_d = FS_IDLE;
        end
        default: state_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      armed_q <= 1'b0;
      xmit_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      armed_q <= arm_evt | (armed_q & ~mem_etx_hit);
      xmit_q  <= armed_q & mem_etx_hit;
      if (subst_evt && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign frame_open = (state_q == FS_ADDR) || (state_q == FS_BODY);
  assign rx_enable  = (state_q != FS_MUTE);
  assign etx_armed  = armed_q;
  assign xmit_start = xmit_q;
  assign perr_count = cnt_q;

  a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (subst_evt && perr_count != CNT_MAX) |=> perr_count == $past(perr_count) + 1'b1);
  a_r6_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_count == CNT_MAX) |=> perr_count == CNT_MAX);
  a_r6_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !subst_evt |=> $stable(perr_count));
  a_r5_blank_pushed: assert property (@(posedge clk) disable iff (!rst_n)
    subst_evt |-> (push && push_data == CODE_BLANK && frame_open));
  a_r9_mute_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |-> !push);
  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_open && rx_enable) |-> !push);
  a_r11_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_start |-> $past(etx_armed && mem_etx_hit));
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_start |=> !xmit_start);
endmodule

// File: rtl/rxps_stage_chain.sv
module rxps_stage_chain
  import rxps_pkg::*;
#(
  parameter int NSTAGE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [CHAR_W-1:0] push_data,
  input  logic              mem_slot,
  output logic              mem_wr,
  output logic [CHAR_W-1:0] mem_data,
  output logic              room
);
  localparam int LAST = NSTAGE - 1;

  logic [NSTAGE-1:0] busy;
  logic [NSTAGE-1:0] moving;
  logic [NSTAGE-1:0] loading;
  logic [CHAR_W-1:0] stage_q [NSTAGE];
  logic [CHAR_W-1:0] stage_in [NSTAGE];

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i == LAST) begin : g_tail
      assign moving[i] = busy[i] & mem_slot;
    end else begin : g_mid
      // strict hand-off: the next stage must already be empty
      assign moving[i] = busy[i] & ~busy[i+1];
    end

    if (i == 0) begin : g_head
      assign loading[i]  = push;
      assign stage_in[i] = push_data;
    end else begin : g_link
      assign loading[i]  = moving[i-1];
      assign stage_in[i] = stage_q[i-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[i]    <= 1'b0;
        stage_q[i] <= '0;
      end else begin
        busy[i] <= (busy[i] & ~moving[i]) | loading[i];
        if (loading[i]) stage_q[i] <= stage_in[i];
      end
    end
  end

  assign room     = ~busy[0] | moving[0];
  assign mem_wr   = moving[LAST];
  assign mem_data = stage_q[LAST];

  a_r7_write_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_slot);
  a_r7_head_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> room);
  a_r7_tail_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy[LAST] && !mem_slot) |=> (busy[LAST] && $stable(mem_data)));
endmodule

// File: rtl/rx_parity_subst.sv
module rx_parity_subst
  import rxps_pkg::*;
#(
  parameter bit ODD_PARITY = 1'b1,
  parameter int NSTAGE     = 3,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_mode,
  input  logic              rx_valid,
  input  logic [CHAR_W:0]   rx_char,
  input  logic              mem_slot,
  input  logic              mem_etx_hit,
  output logic              mem_wr,
  output logic [CHAR_W-1:0] mem_data,
  output logic              frame_open,
  output logic              rx_enable,
  output logic              etx_armed,
  output logic              xmit_start,
  output logic [CNT_W-1:0]  perr_count
);
  logic              par_good;
  logic              push;
  logic [CHAR_W-1:0] push_data;
  logic              subst_evt;
  logic              room;

  rxps_parity_check #(.ODD_PARITY(ODD_PARITY)) u_par (
    .char_in  (rx_char),
    .par_good (par_good)
  );

  rxps_frame_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_mode   (poll_mode),
    .rx_valid    (rx_valid),
    .rx_data     (rx_char[CHAR_W-1:0]),
    .par_good    (par_good),
    .mem_etx_hit (mem_etx_hit),
    .push        (push),
    .push_data   (push_data),
    .subst_evt   (subst_evt),
    .frame_open  (frame_open),
    .rx_enable   (rx_enable),
    .etx_armed   (etx_armed),
    .xmit_start  (xmit_start),
    .perr_count  (perr_count)
  );

  rxps_stage_chain #(.NSTAGE(NSTAGE)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .mem_slot  (mem_slot),
    .mem_wr    (mem_wr),
    .mem_data  (mem_data),
    .room      (room)
  );

  a_r5_subst_only_bad: assert property (@(posedge clk) disable iff (!rst_n)
    subst_evt |-> (rx_valid && (^rx_char) != ODD_PARITY));
  a_r1_no_write_after_reset: assert property (@(posedge clk)
    !rst_n |=> !mem_wr);
endmodule

// File: tb/rx_parity_subst_test.sv
module rx_parity_subst_test;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll_mode = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_char = '0;
  logic mem_slot = 1'b0;
  logic mem_etx_hit = 1'b0;
  logic mem_wr;
  logic [6:0] mem_data;
  logic frame_open, rx_enable, etx_armed, xmit_start;
  logic [CW-1:0] perr_count;

  rx_parity_subst #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .poll_mode(poll_mode), .rx_valid(rx_valid),
    .rx_char(rx_char), .mem_slot(mem_slot), .mem_etx_hit(mem_etx_hit),
    .mem_wr(mem_wr), .mem_data(mem_data), .frame_open(frame_open),
    .rx_enable(rx_enable), .etx_armed(etx_armed), .xmit_start(xmit_start),
    .perr_count(perr_count)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit slot_always = 1'b0;
  bit done = 1'b0;
  int cyc = 0;
  logic [6:0] expq[$];

  int  m_state = 0;   // 0 wait, 1 address, 2 body, 3 muted
  int  m_count = 0;
  bit  m_armed = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [7:0] mk(input logic [6:0] d, input bit good);
    logic p;
    p = good ? ~(^d) : (^d);
    return {p, d};
  endfunction

  function automatic bit odd_ok(input logic [7:0] c);
    return (^c) == 1'b1;
  endfunction

  // memory slot driver
  always @(negedge clk) begin
    cyc++;
    mem_slot = slot_always | ($urandom % 2 == 1) | (cyc % 3 == 0);
  end

  // memory write monitor
  always @(negedge clk) begin
    #3;
    if (mem_wr) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R7 unexpected write", mem_data, 0);
      end else begin
        logic [6:0] e;
        e = expq.pop_front();
        chk(mem_data == e, "R4 R5 write order/content", mem_data, e);
      end
    end
  end

  task automatic model(input logic [7:0] c);
    logic [6:0] d;
    d = c[6:0];
    case (m_state)
      0: if (d == 7'h02) m_state = 1;
      1: begin
        if (poll_mode && d[6]) m_state = 3;
        else begin expq.push_back(d); m_state = 2; end
      end
      2: begin
        if (odd_ok(c)) begin
          expq.push_back(d);
          if (d == 7'h03) m_state = 0;
        end else begin
          expq.push_back(7'h1A);
          if (m_count < (1 << CW) - 1) m_count++;
        end
      end
      default: begin
        if (d == 7'h03) m_armed = 1'b1;
        m_state = 0;
      end
    endcase
  endtask

  task automatic check_flags(input string req);
    chk(frame_open == (m_state == 1 || m_state == 2), {req, " frame_open"}, frame_open, (m_state == 1 || m_state == 2));
    chk(rx_enable == (m_state != 3), {req, " rx_enable"}, rx_enable, (m_state != 3));
    chk(etx_armed == m_armed, {req, " etx_armed"}, etx_armed, m_armed);
    chk(perr_count == CW'(m_count), "R6 perr_count", perr_count, m_count);
  endtask

  task automatic send(input logic [7:0] c, input string req);
    model(c);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_char  = c;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (9) @(negedge clk);
    #1;
    check_flags(req);
  endtask

  task automatic hit_pulse(input string req);
    bit was;
    was = m_armed;
    @(negedge clk);
    mem_etx_hit = 1'b1;
    @(negedge clk);
    mem_etx_hit = 1'b0;
    #1;
    chk(xmit_start == was, {req, " pulse"}, xmit_start, was);
    chk(etx_armed == 1'b0, {req, " arm cleared"}, etx_armed, 0);
    m_armed = 1'b0;
    @(negedge clk);
    #1;
    chk(xmit_start == 1'b0, {req, " pulse width"}, xmit_start, 0);
  endtask

  task automatic random_frame(input bit poll, input bit mute);
    logic [6:0] a;
    int n;
    poll_mode = poll;
    send(mk(7'h02, 1'b1), "R2");
    a = 7'($urandom);
    if (poll) a[6] = mute;
    send(mk(a, 1'b1), mute ? "R9" : "R3");
    if (mute) begin
      send(mk(($urandom % 2) ? 7'h03 : 7'h41, 1'b1), "R9");
    end else begin
      n = 2 + $urandom % 6;
      for (int i = 0; i < n; i++) begin
        logic [6:0] d;
        d = 7'($urandom);
        if (d == 7'h03) d = 7'h04;
        send(mk(d, ($urandom % 5) != 0), "R4");
      end
      send(mk(7'h03, 1'b1), "R8");
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(mem_wr == 1'b0, "R1 mem_wr", mem_wr, 0);
    chk(frame_open == 1'b0, "R1 frame_open", frame_open, 0);
    chk(rx_enable == 1'b1, "R1 rx_enable", rx_enable, 1);
    chk(etx_armed == 1'b0, "R1 etx_armed", etx_armed, 0);
    chk(xmit_start == 1'b0, "R1 xmit_start", xmit_start, 0);
    chk(perr_count == '0, "R1 perr_count", perr_count, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 characters before start-of-text are dropped
    send(mk(7'h41, 1'b1), "R2");
    send(mk(7'h03, 1'b0), "R2");
    chk(expq.size() == 0, "R2 nothing queued", expq.size(), 0);

    // R7 latency with slot always open
    slot_always = 1'b1;
    send(mk(7'h02, 1'b1), "R2");
    model(mk(7'h55, 1'b0));
    @(negedge clk);
    rx_valid = 1'b1;
    rx_char  = mk(7'h55, 1'b0);
    @(negedge clk);
    rx_valid = 1'b0;
    #2 chk(mem_wr == 1'b0, "R7 latency edge+1", mem_wr, 0);
    @(negedge clk);
    #2 chk(mem_wr == 1'b0, "R7 latency edge+2", mem_wr, 0);
    @(negedge clk);
    #2 chk(mem_wr == 1'b1 && mem_data == 7'h55, "R7 R3 latency edge+3", mem_data, 7'h55);
    repeat (6) @(negedge clk);
    check_flags("R3");
    slot_always = 1'b0;

    // R5 and R8 directed body
    send(mk(7'h31, 1'b1), "R4");
    send(mk(7'h32, 1'b0), "R5");
    send(mk(7'h03, 1'b0), "R8");
    chk(frame_open == 1'b1, "R8 bad end-of-text keeps frame", frame_open, 1);
    send(mk(7'h03, 1'b1), "R8");

    // R10 address top bit ignored outside polling
    poll_mode = 1'b0;
    send(mk(7'h02, 1'b1), "R10");
    send(mk(7'h7F, 1'b0), "R10");
    chk(frame_open == 1'b1 && rx_enable == 1'b1, "R10 frame stays open", frame_open, 1);
    send(mk(7'h03, 1'b1), "R8");

    // R9 muted address followed by a non end-of-text character
    poll_mode = 1'b1;
    send(mk(7'h02, 1'b1), "R9");
    send(mk(7'h45, 1'b1), "R9");
    chk(rx_enable == 1'b0, "R9 receive enable dropped", rx_enable, 0);
    send(mk(7'h20, 1'b1), "R9");

    // random mixture
    for (int f = 0; f < 40; f++) begin
      bit poll;
      poll = ($urandom % 2) == 1;
      random_frame(poll, poll && ($urandom % 3 == 0));
    end

    // R11 clear any arm, then arm and fire
    hit_pulse("R11");
    hit_pulse("R11 idle hit");
    poll_mode = 1'b1;
    send(mk(7'h02, 1'b1), "R9");
    send(mk(7'h45, 1'b1), "R9");
    send(mk(7'h03, 1'b1), "R9");
    chk(etx_armed == 1'b1, "R9 arm set", etx_armed, 1);
    hit_pulse("R11");

    // R11 coincidence, with and without an older arm
    for (int k = 0; k < 2; k++) begin
      bit was;
      if (k == 1) begin
        send(mk(7'h02, 1'b1), "R9");
        send(mk(7'h45, 1'b1), "R9");
        send(mk(7'h03, 1'b1), "R9");
      end
      send(mk(7'h02, 1'b1), "R9");
      send(mk(7'h46, 1'b1), "R9");
      was = m_armed;
      @(negedge clk);
      rx_valid = 1'b1;
      rx_char = mk(7'h03, 1'b1);
      mem_etx_hit = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      mem_etx_hit = 1'b0;
      #1;
      chk(xmit_start == was, "R11 coincident pulse", xmit_start, was);
      chk(etx_armed == 1'b1, "R11 new arm kept", etx_armed, 1);
      m_armed = 1'b1;
      m_state = 0;
      repeat (3) @(negedge clk);
      #1;
      check_flags("R11");
    end
    hit_pulse("R11");

    // R6 saturation
    poll_mode = 1'b0;
    send(mk(7'h02, 1'b1), "R6");
    send(mk(7'h10, 1'b1), "R6");
    for (int i = 0; i < 20; i++) send(mk(7'(i + 8), 1'b0), "R6");
    chk(perr_count == {CW{1'b1}}, "R6 saturated", perr_count, (1 << CW) - 1);
    send(mk(7'h03, 1'b1), "R8");

    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R7 all characters delivered", expq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule